// File: doc/BRIEF.md
# Serial port status flag controller

This block keeps the six status flags of an asynchronous serial port and the received byte that the processor reads. The transmit and receive datapaths report events to it: a transmit-data-empty level, a shifter-busy level, a one-cycle strobe when a received word is complete, and the framing and noise verdicts for that word. Line samples from the bit sampler drive an idle detector that counts consecutive high samples.

The processor sees the flags on a status bus and the held byte on a data bus. A flag is cleared by a two-step sequence. First a status read takes a snapshot of which flags are set. Then a data-register access clears only the flags in that snapshot: a data read clears the receive-side flags, and a data write clears transmit-complete. A word that completes while the held byte is still unread is dropped and raises overrun, and that word cannot raise a framing error. One interrupt request combines the flag sources, each gated by its enable bit.

Top module: `serstat_ctrl`

## Requirements
- R1: A synchronous active-high reset gives `stat_o` = 6'b000001 and `rx_data` = 0. The status bit order is [0] transmit-complete, [1] receive-full, [2] idle, [3] overrun, [4] noise, [5] framing.
- R2: Transmit-complete sets on any cycle in which `tx_empty` is 1 and `tx_busy` is 0. It clears on a `dr_wr` when an earlier `st_rd` saw it set, and only if the set condition is false in that cycle.
- R3: A `rx_done` strobe while receive-full is 0 loads `rx_word` into `rx_data` and sets receive-full. A `st_rd` that sees receive-full set, followed by a `dr_rd`, clears it.
- R4: A `rx_done` strobe while receive-full is 1 sets overrun and leaves `rx_data` and receive-full unchanged. A word that completes in the same cycle as the `dr_rd` that clears receive-full is accepted, and overrun does not set.
- R5: A word dropped by overrun raises neither the framing flag nor the noise flag, even when `rx_frame_bad` or `rx_noisy` is 1.
- R6: An accepted word with `rx_frame_bad` = 1 sets the framing flag, and one with `rx_noisy` = 1 sets the noise flag. Overrun, noise and framing each clear by a `st_rd` that sees them set, followed by a `dr_rd`.
- R7: Idle sets on the edge of the IDLE_SHORT-th consecutive high sample (`rx_sample_en` with `rx_line` = 1) when `long_char` = 0, or the IDLE_LONG-th when `long_char` = 1. A low sample or a `rx_char_start` pulse restarts the count.
- R8: After idle has fired, at least one low sample must arrive before idle can set again.
- R9: The clearing data access clears a flag only if that flag was set at the time of the status read. A flag that sets after the status read survives the access.
- R10: A `dr_rd` or `dr_wr` with no earlier status read that saw the flag set clears nothing.
- R11: `irq` is 1 when transmit-complete and `en_tx_int` are both 1, when receive-full or overrun is 1 with `en_rx_int`, or when idle is 1 with `en_idle_int`. Noise and framing never raise `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_empty | input | 1 | Transmit data register empty (level) |
| tx_busy | input | 1 | Data, preamble or break being shifted out (level) |
| rx_done | input | 1 | Received word complete (strobe) |
| rx_word | input | DATA_W | Received word |
| rx_frame_bad | input | 1 | Stop position of the word held a 0 |
| rx_noisy | input | 1 | Noise seen in the word |
| rx_sample_en | input | 1 | Line sample valid |
| rx_line | input | 1 | Sampled line level |
| rx_char_start | input | 1 | Start of a character (strobe) |
| long_char | input | 1 | Selects the long idle threshold |
| st_rd | input | 1 | Status register read strobe |
| dr_rd | input | 1 | Data register read strobe |
| dr_wr | input | 1 | Data register write strobe |
| en_tx_int | input | 1 | Transmit-complete interrupt enable |
| en_rx_int | input | 1 | Receive-full and overrun interrupt enable |
| en_idle_int | input | 1 | Idle interrupt enable |
| stat_o | output | 6 | Status flags, bit order as in R1 |
| rx_data | output | DATA_W | Held received byte |
| irq | output | 1 | Combined interrupt request |

## Verification
Every flag is a register, so a wrong snapshot or wrong set/clear priority appears on `stat_o` on the edge that follows the offending strobe. A lost or stale snapshot shows one access later, as a flag that should have cleared but stays set, or one that clears without being armed. Errors in overrun handling appear as a changed `rx_data` or a stray framing bit one cycle after the second word. An idle counter that is off by one shows as idle rising one sample early or late, or rising again with no low sample in between.

// File: rtl/serstat_pkg.sv
package serstat_pkg;
   localparam int FLAG_N  = 6;
   localparam int FL_TC   = 0;
   localparam int FL_RF   = 1;
   localparam int FL_IDLE = 2;
   localparam int FL_OV   = 3;
   localparam int FL_NF   = 4;
   localparam int FL_FE   = 5;
   localparam logic [FLAG_N-1:0] FLAG_RST = 6'b000001;
endpackage

// File: rtl/serstat_flag_cell.sv
module serstat_flag_cell #(
   parameter logic RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst,
   input  logic set_i,
   input  logic snap_i,
   input  logic acc_i,
   output logic hit_o,
   output logic flag_o
);
   logic flag_q;
   logic arm_q;

   assign hit_o  = acc_i & arm_q;
   assign flag_o = flag_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         flag_q <= RST_VAL;
         arm_q  <= 1'b0;
      end else begin
         flag_q <= set_i | (flag_q & ~hit_o);
         if (snap_i)
            arm_q <= flag_q;
         else if (acc_i)
            arm_q <= 1'b0;
      end
   end
endmodule

// File: rtl/serstat_idle_det.sv
module serstat_idle_det #(
   parameter int IDLE_SHORT = 10,
   parameter int IDLE_LONG  = 11
) (
   input  logic clk,
   input  logic rst,
   input  logic smp_en,
   input  logic line_i,
   input  logic char_start,
   input  logic long_sel,
   output logic fire_o
);
   localparam int CNT_W = $clog2(IDLE_LONG + 1);
   localparam logic [CNT_W-1:0] LAST_S = CNT_W'(IDLE_SHORT - 1);
   localparam logic [CNT_W-1:0] LAST_L = CNT_W'(IDLE_LONG - 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] last;
   logic             armed_q;
   logic             at_last;

   generate
      if (IDLE_SHORT == IDLE_LONG) begin : g_fixed
         logic unused_sel;
         assign unused_sel = long_sel;
         assign last = LAST_S;
      end else begin : g_select
         assign last = long_sel ? LAST_L : LAST_S;
      end
   endgenerate

   assign at_last = (cnt_q == last);
   assign fire_o  = smp_en & line_i & armed_q & at_last & ~char_start;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         armed_q <= 1'b1;
      end else if (char_start) begin
         cnt_q <= '0;
      end else if (smp_en) begin
         if (!line_i) begin
            cnt_q   <= '0;
            armed_q <= 1'b1;
         end else if (armed_q) begin
            if (at_last) begin
               cnt_q   <= '0;
               armed_q <= 1'b0;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
      end
   end
endmodule

// File: rtl/serstat_rx_hold.sv
module serstat_rx_hold #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              done_i,
   input  logic [DATA_W-1:0] word_i,
   input  logic              frame_bad_i,
   input  logic              noisy_i,
   input  logic              full_i,
   input  logic              full_hit_i,
   output logic [DATA_W-1:0] data_o,
   output logic              rf_set_o,
   output logic              ov_set_o,
   output logic              fe_set_o,
   output logic              nf_set_o
);
   logic              room;
   logic              take;
   logic [DATA_W-1:0] data_q;

   assign room     = ~full_i | full_hit_i;
   assign take     = done_i & room;
   assign rf_set_o = take;
   assign ov_set_o = done_i & ~room;
   assign fe_set_o = take & frame_bad_i;
   assign nf_set_o = take & noisy_i;
   assign data_o   = data_q;

   always_ff @(posedge clk) begin
      if (rst)
         data_q <= '0;
      else if (take)
         data_q <= word_i;
   end
endmodule

// File: rtl/serstat_ctrl.sv
module serstat_ctrl
   import serstat_pkg::*;
#(
   parameter int DATA_W     = 8,
   parameter int IDLE_SHORT = 10,
   parameter int IDLE_LONG  = 11
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              tx_empty,
   input  logic              tx_busy,
   input  logic              rx_done,
   input  logic [DATA_W-1:0] rx_word,
   input  logic              rx_frame_bad,
   input  logic              rx_noisy,
   input  logic              rx_sample_en,
   input  logic              rx_line,
   input  logic              rx_char_start,
   input  logic              long_char,
   input  logic              st_rd,
   input  logic              dr_rd,
   input  logic              dr_wr,
   input  logic              en_tx_int,
   input  logic              en_rx_int,
   input  logic              en_idle_int,
   output logic [5:0]        stat_o,
   output logic [DATA_W-1:0] rx_data,
   output logic              irq
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("serstat_ctrl: DATA_W must be at least 1");
      end
      if (IDLE_SHORT < 2) begin : g_bad_short
         $error("serstat_ctrl: IDLE_SHORT must be at least 2");
      end
      if (IDLE_LONG < IDLE_SHORT) begin : g_bad_long
         $error("serstat_ctrl: IDLE_LONG must not be below IDLE_SHORT");
      end
   endgenerate

   logic [FLAG_N-1:0] set_v;
   logic [FLAG_N-1:0] acc_v;
   logic [FLAG_N-1:0] hit_v;
   logic [FLAG_N-1:0] flag_v;
   logic rf_set, ov_set, fe_set, nf_set, idle_set;

   serstat_rx_hold #(.DATA_W(DATA_W)) u_hold (
      .clk         (clk),
      .rst         (rst),
      .done_i      (rx_done),
      .word_i      (rx_word),
      .frame_bad_i (rx_frame_bad),
      .noisy_i     (rx_noisy),
      .full_i      (flag_v[FL_RF]),
      .full_hit_i  (hit_v[FL_RF]),
      .data_o      (rx_data),
      .rf_set_o    (rf_set),
      .ov_set_o    (ov_set),
      .fe_set_o    (fe_set),
      .nf_set_o    (nf_set)
   );

   serstat_idle_det #(.IDLE_SHORT(IDLE_SHORT), .IDLE_LONG(IDLE_LONG)) u_idle (
      .clk        (clk),
      .rst        (rst),
      .smp_en     (rx_sample_en),
      .line_i     (rx_line),
      .char_start (rx_char_start),
      .long_sel   (long_char),
      .fire_o     (idle_set)
   );

   always_comb begin
      set_v          = '0;
      set_v[FL_TC]   = tx_empty & ~tx_busy;
      set_v[FL_RF]   = rf_set;
      set_v[FL_IDLE] = idle_set;
      set_v[FL_OV]   = ov_set;
      set_v[FL_NF]   = nf_set;
      set_v[FL_FE]   = fe_set;
      acc_v          = {FLAG_N{dr_rd}};
      acc_v[FL_TC]   = dr_wr;
   end

   for (genvar g = 0; g < FLAG_N; g++) begin : g_flag
      serstat_flag_cell #(.RST_VAL(FLAG_RST[g])) u_cell (
         .clk    (clk),
         .rst    (rst),
         .set_i  (set_v[g]),
         .snap_i (st_rd),
         .acc_i  (acc_v[g]),
         .hit_o  (hit_v[g]),
         .flag_o (flag_v[g])
      );
   end

   assign stat_o = flag_v;
   assign irq = (flag_v[FL_TC] & en_tx_int)
              | ((flag_v[FL_RF] | flag_v[FL_OV]) & en_rx_int)
              | (flag_v[FL_IDLE] & en_idle_int);
endmodule

// File: rtl/serstat_ctrl_chk.sv
module serstat_ctrl_chk #(
   parameter int DATA_W = 8
) (
   input logic              clk,
   input logic              rst,
   input logic              tx_empty,
   input logic              tx_busy,
   input logic              rx_done,
   input logic              rx_sample_en,
   input logic              rx_line,
   input logic              dr_rd,
   input logic              dr_wr,
   input logic              en_tx_int,
   input logic              en_rx_int,
   input logic              en_idle_int,
   input logic [5:0]        stat_o,
   input logic [DATA_W-1:0] rx_data,
   input logic              irq
);
   logic rst_d;
   always_ff @(posedge clk) rst_d <= rst;

   // R1: state right after a reset edge
   always @(posedge clk)
      if (rst_d === 1'b1)
         a_r1_reset_state: assert (stat_o == 6'b000001 && rx_data == '0);

   a_r2_tc_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(stat_o[0]) |-> $past(tx_empty && !tx_busy));

   a_r3_rf_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(stat_o[1]) |-> $past(rx_done));

   a_r4_overrun_keeps: assert property (@(posedge clk) disable iff (rst)
      rx_done && stat_o[1] && !dr_rd |=> stat_o[3] && stat_o[1] && rx_data == $past(rx_data));

   a_r5_no_frame_on_ovr: assert property (@(posedge clk) disable iff (rst)
      rx_done && stat_o[1] && !dr_rd && !stat_o[5] |=> !stat_o[5]);

   a_r7_idle_rise: assert property (@(posedge clk) disable iff (rst)
      $rose(stat_o[2]) |-> $past(rx_sample_en && rx_line));

   a_r10_tc_fall: assert property (@(posedge clk) disable iff (rst)
      $fell(stat_o[0]) |-> $past(dr_wr));

   for (genvar k = 1; k < 6; k++) begin : g_fall
      a_r10_rx_fall: assert property (@(posedge clk) disable iff (rst)
         $fell(stat_o[k]) |-> $past(dr_rd));
   end

   a_r11_irq_gated: assert property (@(posedge clk) disable iff (rst)
      !en_tx_int && !en_rx_int && !en_idle_int |-> !irq);
endmodule

bind serstat_ctrl serstat_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst          (rst),
   .tx_empty     (tx_empty),
   .tx_busy      (tx_busy),
   .rx_done      (rx_done),
   .rx_sample_en (rx_sample_en),
   .rx_line      (rx_line),
   .dr_rd        (dr_rd),
   .dr_wr        (dr_wr),
   .en_tx_int    (en_tx_int),
   .en_rx_int    (en_rx_int),
   .en_idle_int  (en_idle_int),
   .stat_o       (stat_o),
   .rx_data      (rx_data),
   .irq          (irq)
);

// File: tb/serstat_ctrl_test.sv
`timescale 1ns/1ps
module serstat_ctrl_test;
   logic clk = 1'b0;
   logic rst = 1'b1;
   logic tx_empty = 0, tx_busy = 0, rx_done = 0, rx_frame_bad = 0, rx_noisy = 0;
   logic rx_sample_en = 0, rx_line = 1, rx_char_start = 0, long_char = 0;
   logic st_rd = 0, dr_rd = 0, dr_wr = 0;
   logic en_tx_int = 1, en_rx_int = 1, en_idle_int = 1;
   logic [7:0] rx_word = 8'h00;
   logic [5:0] stat_o;
   logic [7:0] rx_data;
   logic irq;
   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   always #4 clk = ~clk;

   serstat_ctrl uut (
      .clk(clk), .rst(rst), .tx_empty(tx_empty), .tx_busy(tx_busy),
      .rx_done(rx_done), .rx_word(rx_word), .rx_frame_bad(rx_frame_bad),
      .rx_noisy(rx_noisy), .rx_sample_en(rx_sample_en), .rx_line(rx_line),
      .rx_char_start(rx_char_start), .long_char(long_char), .st_rd(st_rd),
      .dr_rd(dr_rd), .dr_wr(dr_wr), .en_tx_int(en_tx_int), .en_rx_int(en_rx_int),
      .en_idle_int(en_idle_int), .stat_o(stat_o), .rx_data(rx_data), .irq(irq));

   // row: {tx_empty,tx_busy,rx_done,frame_bad,noisy,st_rd,dr_rd,dr_wr, word, exp_stat, exp_data}
   localparam int NROW = 21;
   localparam logic [29:0] VEC [NROW] = '{
      {8'b00000000, 8'h00, 6'b000001, 8'h00},
      {8'b00000100, 8'h00, 6'b000001, 8'h00},
      {8'b00000001, 8'h00, 6'b000000, 8'h00},
      {8'b11000000, 8'h00, 6'b000000, 8'h00},
      {8'b10000000, 8'h00, 6'b000001, 8'h00},
      {8'b00100000, 8'hA5, 6'b000011, 8'hA5},
      {8'b00111000, 8'h3C, 6'b001011, 8'hA5},
      {8'b00000010, 8'h00, 6'b001011, 8'hA5},
      {8'b00000100, 8'h00, 6'b001011, 8'hA5},
      {8'b00110000, 8'h77, 6'b001011, 8'hA5},
      {8'b00000010, 8'h00, 6'b000001, 8'hA5},
      {8'b00111000, 8'h5A, 6'b110011, 8'h5A},
      {8'b00000100, 8'h00, 6'b110011, 8'h5A},
      {8'b00100000, 8'hC3, 6'b111011, 8'h5A},
      {8'b00000010, 8'h00, 6'b001001, 8'h5A},
      {8'b00000001, 8'h00, 6'b001000, 8'h5A},
      {8'b00000100, 8'h00, 6'b001000, 8'h5A},
      {8'b00000010, 8'h00, 6'b000000, 8'h5A},
      {8'b00100010, 8'h96, 6'b000010, 8'h96},
      {8'b00000100, 8'h00, 6'b000010, 8'h96},
      {8'b00100010, 8'hE1, 6'b000010, 8'hE1}
   };

   function automatic string row_tag(input int i);
      case (i)
         0, 1:       return "R1";
         2, 3, 4:    return "R2";
         5:          return "R3";
         6, 9:       return "R4/R5";
         7:          return "R10";
         10:         return "R4/R6";
         11, 12:     return "R6";
         13, 14:     return "R9";
         15:         return "R2/R9";
         16, 17:     return "R6";
         18:         return "R3/R10";
         default:    return "R4";
      endcase
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic sample(input logic v);
      rx_sample_en = 1'b1; rx_line = v;
      @(negedge clk);
      rx_sample_en = 1'b0; rx_line = 1'b1;
   endtask

   task automatic ones(input int n);
      for (int k = 0; k < n; k++) sample(1'b1);
   endtask

   task automatic clear_seq();
      st_rd = 1'b1; @(negedge clk); st_rd = 1'b0;
      dr_rd = 1'b1; @(negedge clk); dr_rd = 1'b0;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst = 1'b0;
      for (int i = 0; i < NROW; i++) begin
         {tx_empty, tx_busy, rx_done, rx_frame_bad, rx_noisy, st_rd, dr_rd, dr_wr} = VEC[i][29:22];
         rx_word = VEC[i][21:14];
         @(negedge clk);
         check({row_tag(i), " stat"}, 32'(stat_o), 32'(VEC[i][13:8]));
         check({row_tag(i), " data"}, 32'(rx_data), 32'(VEC[i][7:0]));
         check("R11 irq all enabled", 32'(irq),
               32'(VEC[i][8] | VEC[i][9] | VEC[i][10] | VEC[i][11]));
         {tx_empty, tx_busy, rx_done, rx_frame_bad, rx_noisy, st_rd, dr_rd, dr_wr} = '0;
      end
      // state now: receive-full only
      en_tx_int = 0; en_idle_int = 0; en_rx_int = 1; #1;
      check("R11 rx enable", 32'(irq), 32'd1);
      en_rx_int = 0; en_tx_int = 1; #1;
      check("R11 tx enable, tc clear", 32'(irq), 32'd0);
      en_tx_int = 0; #1;
      check("R11 no enables", 32'(irq), 32'd0);
      clear_seq();
      check("R3 receive-full cleared", 32'(stat_o), 32'd0);

      // idle detection, short threshold
      long_char = 0;
      ones(9);
      check("R7 9 highs short", 32'(stat_o[2]), 32'd0);
      ones(1);
      check("R7 10th high short", 32'(stat_o[2]), 32'd1);
      en_idle_int = 1; #1;
      check("R11 idle enable", 32'(irq), 32'd1);
      en_idle_int = 0;
      clear_seq();
      check("R7 idle cleared", 32'(stat_o[2]), 32'd0);
      ones(15);
      check("R8 no refire without low", 32'(stat_o[2]), 32'd0);
      sample(1'b0);
      ones(10);
      check("R8 refire after low", 32'(stat_o[2]), 32'd1);
      clear_seq();
      sample(1'b0);
      long_char = 1;
      ones(10);
      check("R7 10 highs long", 32'(stat_o[2]), 32'd0);
      ones(1);
      check("R7 11th high long", 32'(stat_o[2]), 32'd1);
      clear_seq();
      sample(1'b0);
      long_char = 0;
      ones(5); sample(1'b0); ones(9);
      check("R7 low restarts count", 32'(stat_o[2]), 32'd0);
      ones(1);
      check("R7 count after restart", 32'(stat_o[2]), 32'd1);
      clear_seq();
      sample(1'b0);
      ones(6);
      rx_char_start = 1; @(negedge clk); rx_char_start = 0;
      ones(9);
      check("R7 char start restarts count", 32'(stat_o[2]), 32'd0);
      ones(1);
      check("R7 count after char start", 32'(stat_o[2]), 32'd1);

      // frame/noise raise no interrupt
      clear_seq();
      rx_done = 1; rx_word = 8'h42; rx_frame_bad = 1; rx_noisy = 1;
      @(negedge clk);
      rx_done = 0; rx_frame_bad = 0; rx_noisy = 0;
      st_rd = 1; @(negedge clk); st_rd = 0;
      rx_done = 1; rx_word = 8'h00; @(negedge clk); rx_done = 0;
      dr_rd = 1; @(negedge clk); dr_rd = 0;
      check("R9 overrun after snapshot stays", 32'(stat_o), 32'b001000);
      check("R4 data kept", 32'(rx_data), 32'h42);
      en_tx_int = 0; en_rx_int = 0; en_idle_int = 1; #1;
      check("R11 only idle enabled", 32'(irq), 32'd0);

      // mid-run reset
      rst = 1; @(negedge clk); @(negedge clk); rst = 0;
      check("R1 reset stat", 32'(stat_o), 32'b000001);
      check("R1 reset data", 32'(rx_data), 32'h00);

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule